// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table kept in main memory. A requester presents an address and an access kind (read or write). The walker reads a top-level entry that points to a leaf table. It then reads the leaf entry and answers with either the translated physical address or a fault code. It serves one walk at a time.

Pages are 8 KB. The 13 low address bits are the offset inside the page and are never translated. The remaining 19 bits form two indexes: a 10-bit top-level index (bits 31:22) and a 9-bit leaf index (bits 21:13). Two inputs set the table layout, and they are expected to stay still while a walk runs:

- a table-root address, giving where the top-level table starts;
- a table-length value, giving how many top-level entries are legal.

When a translation succeeds, the walker keeps the leaf entry's usage bits up to date through the same memory port. It writes the entry back only when a bit actually changes.

Top module: `ptw_top`

## Requirements
- R1: A successful response carries `{frame, offset}`. The frame is leaf-entry bits 31:13 and the offset is request bits 12:0, unchanged. Every fault response carries a physical address of zero.
- R2: The top-level entry is read at `root + 4*idx_top`. Its bits 31:11 followed by `idx_leaf` and `2'b00` give the leaf-entry address. A memory request holds its address and write flag until `mem_ack`.
- R3: A top-level entry with bit 0 (valid) clear ends the walk with status 1 (page fault) after exactly one memory read.
- R4: A leaf entry with bit 0 (valid) clear gives status 1 whatever its other bits hold. There are two reads and no write.
- R5: When `idx_top` is greater than or equal to the table-length input, the status is 3 (limit fault) and no memory access is made. An index one below the length is walked.
- R6: A write request to a leaf entry whose bit 3 (write permission) is clear gives status 2 (protection fault). The entry is not written back. A read to the same page succeeds.
- R7: A successful walk sets leaf bit 1 (referenced), and a write also sets bit 2 (dirty). Exactly one write-back is made when the entry changes, and none when it is already up to date. Status 0 marks success.
- R8: `req_ready` is high only while idle. It drops in the cycle after a request is accepted and stays low through the response. `rsp_valid` is a single-cycle pulse, and `req_ready` returns in the next cycle.
- R9: After reset, `req_ready` is high and both `rsp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_status | output | 2 | 0 ok, 1 page fault, 2 protection fault, 3 limit fault |
| tbl_root | input | 32 | Physical address of the top-level table |
| tbl_len | input | 11 | Number of legal top-level entries (0 to 1024) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Physical byte address of the table entry |
| mem_wdata | output | 32 | Updated leaf entry for a write-back |
| mem_ack | input | 1 | Memory completes the current access |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
Translations are tried against leaf entries in several states:

- Entries whose usage bits are clear, partly set or fully set. These separate a walk that must write back from one that must not, and show whether the dirty bit is set only on writes.
- Entries that are invalid, and entries that deny writing. These separate the page fault from the protection fault, and show that a fault never touches memory with a write.
- Addresses at the index and offset extremes, such as a leaf index of 511 and an offset of 0x1FFF. These show that the frame and offset are joined without carry or shift errors.
- Indexes just below and at the table-length value, including a length of zero and of 1024. These show where the limit check cuts off and that it makes no memory read.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int unsigned VA_W     = 32;
    localparam int unsigned PA_W     = 32;
    localparam int unsigned PTE_W    = 32;
    localparam int unsigned OFF_W    = 13;
    localparam int unsigned L1_W     = 10;
    localparam int unsigned L2_W     = 9;
    localparam int unsigned ENT_B_W  = 2;
    localparam int unsigned VPN_W    = VA_W - OFF_W;
    localparam int unsigned FRAME_W  = PA_W - OFF_W;
    localparam int unsigned TBL_W    = PA_W - L2_W - ENT_B_W;
    localparam int unsigned LEN_W    = L1_W + 1;

    localparam int unsigned BIT_V  = 0;
    localparam int unsigned BIT_R  = 1;
    localparam int unsigned BIT_D  = 2;
    localparam int unsigned BIT_WR = 3;

    typedef enum logic [1:0] {XL_OK, XL_PAGE, XL_PROT, XL_LIMIT} xl_status_e;
    typedef enum logic [2:0] {W_IDLE, W_L1, W_L2, W_WB, W_RESP} walk_state_e;

    typedef struct packed {
        walk_state_e          st;
        logic [VA_W-1:0]      va;
        logic                 wr;
        logic [TBL_W-1:0]     tbl;
        logic [PTE_W-1:0]     pte_new;
        logic [PA_W-1:0]      pa;
        xl_status_e           status;
    } walk_regs_t;

    localparam walk_regs_t WALK_RST = '{st: W_IDLE, va: '0, wr: 1'b0, tbl: '0,
                                        pte_new: '0, pa: '0, status: XL_OK};
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [VPN_W-1:0] vpn,
    input  logic [PA_W-1:0]  root,
    input  logic [LEN_W-1:0] len,
    input  logic [TBL_W-1:0] tbl,
    output logic [PA_W-1:0]  l1_addr,
    output logic [PA_W-1:0]  l2_addr,
    output logic             over_limit
);
    logic [L1_W-1:0] idx_top;
    logic [L2_W-1:0] idx_leaf;

    assign idx_top  = vpn[VPN_W-1 -: L1_W];
    assign idx_leaf = vpn[L2_W-1:0];

    assign l1_addr    = root + {{(PA_W-L1_W-ENT_B_W){1'b0}}, idx_top, {ENT_B_W{1'b0}}};
    assign l2_addr    = {tbl, idx_leaf, {ENT_B_W{1'b0}}};
    assign over_limit = ({1'b0, idx_top} >= len);
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    input  logic [OFF_W-1:0] offset,
    output xl_status_e       status,
    output logic [PA_W-1:0]  pa,
    output logic [PTE_W-1:0] pte_new,
    output logic             need_wb
);
    logic [PTE_W-1:0] set_mask;

    always_comb begin
        set_mask         = '0;
        set_mask[BIT_R]  = 1'b1;
        set_mask[BIT_D]  = is_write;
        pte_new          = pte | set_mask;
        pa               = {pte[PTE_W-1 -: FRAME_W], offset};
        if (!pte[BIT_V]) begin
            status = XL_PAGE;
        end else if (is_write && !pte[BIT_WR]) begin
            status = XL_PROT;
        end else begin
            status = XL_OK;
        end
        need_wb = (status == XL_OK) && (pte_new != pte);
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_status,
    input  logic [PA_W-1:0]  tbl_root,
    input  logic [LEN_W-1:0] tbl_len,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata
);
    walk_regs_t q, d;

    logic [VPN_W-1:0] vpn_sel;
    logic [PA_W-1:0]  l1_addr, l2_addr;
    logic             over_limit;
    xl_status_e       ev_status;
    logic [PA_W-1:0]  ev_pa;
    logic [PTE_W-1:0] ev_pte_new;
    logic             ev_need_wb;

    assign vpn_sel = (q.st == W_IDLE) ? req_vaddr[VA_W-1:OFF_W] : q.va[VA_W-1:OFF_W];

    ptw_addr_gen u_addr_gen (
        .vpn        (vpn_sel),
        .root       (tbl_root),
        .len        (tbl_len),
        .tbl        (q.tbl),
        .l1_addr    (l1_addr),
        .l2_addr    (l2_addr),
        .over_limit (over_limit)
    );

    ptw_pte_eval u_pte_eval (
        .pte      (mem_rdata),
        .is_write (q.wr),
        .offset   (q.va[OFF_W-1:0]),
        .status   (ev_status),
        .pa       (ev_pa),
        .pte_new  (ev_pte_new),
        .need_wb  (ev_need_wb)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            W_IDLE: begin
                if (req_valid) begin
                    d.va     = req_vaddr;
                    d.wr     = req_write;
                    d.pa     = '0;
                    d.status = XL_OK;
                    if (over_limit) begin
                        d.status = XL_LIMIT;
                        d.st     = W_RESP;
                    end else begin
                        d.st     = W_L1;
                    end
                end
            end
            W_L1: begin
                if (mem_ack) begin
                    if (!mem_rdata[BIT_V]) begin
                        d.status = XL_PAGE;
                        d.st     = W_RESP;
                    end else begin
                        d.tbl    = mem_rdata[PTE_W-1 -: TBL_W];
                        d.st     = W_L2;
                    end
                end
            end
            W_L2: begin
                if (mem_ack) begin
                    d.status = ev_status;
                    if (ev_status == XL_OK) begin
                        d.pa      = ev_pa;
                        d.pte_new = ev_pte_new;
                        d.st      = ev_need_wb ? W_WB : W_RESP;
                    end else begin
                        d.st      = W_RESP;
                    end
                end
            end
            W_WB: begin
                if (mem_ack) begin
                    d.st = W_RESP;
                end
            end
            W_RESP: begin
                d.st = W_IDLE;
            end
            default: begin
                d.st = W_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= WALK_RST;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == W_IDLE);
    assign rsp_valid  = (q.st == W_RESP);
    assign rsp_paddr  = q.pa;
    assign rsp_status = q.status;
    assign mem_req    = (q.st == W_L1) || (q.st == W_L2) || (q.st == W_WB);
    assign mem_we     = (q.st == W_WB);
    assign mem_addr   = (q.st == W_L1) ? l1_addr : l2_addr;
    assign mem_wdata  = q.pte_new;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_status,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_ack
);
    logic [OFF_W-1:0] off_q;
    logic             touched_q;
    logic             wrote_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q     <= '0;
            touched_q <= 1'b0;
            wrote_q   <= 1'b0;
        end else if (req_valid && req_ready) begin
            off_q     <= req_vaddr[OFF_W-1:0];
            touched_q <= 1'b0;
            wrote_q   <= 1'b0;
        end else begin
            if (mem_req) touched_q <= 1'b1;
            if (mem_req && mem_we) wrote_q <= 1'b1;
        end
    end

    // R8
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R8
    rsp_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R1
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0) |-> (rsp_paddr[OFF_W-1:0] == off_q));

    // R1
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_paddr == '0));

    // R2
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5
    limit_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd3) |-> !touched_q);

    // R6
    prot_no_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd2) |-> !wrote_q);
endmodule

bind ptw_top ptw_checker u_ptw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_status (rsp_status),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack)
);

// File: tb/ptw_top_bench.sv
module ptw_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_status;
    logic [31:0] tbl_root = 32'h0000_2000;
    logic [10:0] tbl_len = 11'd8;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int rd_base = 0;
    int wr_base = 0;
    bit done = 1'b0;

    logic [31:0] mem [0:MEM_WORDS-1];

    typedef struct {
        logic [31:0] pa;
        logic [1:0]  st;
        int          rds;
        int          wrs;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_top u_ptw_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status),
        .tbl_root(tbl_root), .tbl_len(tbl_len),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] leaf(input logic [18:0] fr, input bit v, input bit r,
                                         input bit dty, input bit w);
        return {fr, 9'd0, w, dty, r, v};
    endfunction

    function automatic logic [31:0] mkva(input int p1, input int p2, input int off);
        return {p1[9:0], p2[8:0], off[12:0]};
    endfunction

    // Main-memory stand-in: acknowledges one cycle after a request.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
            mem[2048 + 0] = 32'h0000_1000 | 32'h1;
            mem[2048 + 1] = 32'h0000_1800;
            mem[2048 + 2] = 32'h0000_1800 | 32'h1;
            mem[1024 + 0] = leaf(19'h00012, 1, 0, 0, 1);
            mem[1024 + 3] = leaf(19'h7AAAA, 0, 1, 1, 1);
            mem[1024 + 5] = leaf(19'h00345, 1, 0, 0, 0);
            mem[1536 + 1] = leaf(19'h00077, 1, 1, 0, 1);
            mem[1536 + 511] = leaf(19'h7FFFF, 1, 1, 1, 1);
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[13:2]];
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    wr_cnt++;
                end else begin
                    rd_cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic translate(input logic [31:0] va, input bit wr, input logic [31:0] pa,
                             input logic [1:0] st, input int rds, input int wrs, input string tag);
        exp_t e;
        e.pa = pa; e.st = st; e.rds = rds; e.wrs = wrs; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, $sformatf("R8 ready after accept (%s): actual %0b expected 0", tag, req_ready));
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            int dr, dw;
            dr = rd_cnt - rd_base;
            dw = wr_cnt - wr_base;
            rd_base = rd_cnt;
            wr_base = wr_cnt;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected response: actual 1 expected 0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_paddr == e.pa && rsp_status == e.st && dr == e.rds && dw == e.wrs,
                    $sformatf("%s: actual pa=%h st=%0d rd=%0d wr=%0d expected pa=%h st=%0d rd=%0d wr=%0d",
                              e.tag, rsp_paddr, rsp_status, dr, dw, e.pa, e.st, e.rds, e.wrs));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9
        chk(req_ready && !rsp_valid && !mem_req,
            $sformatf("R9 reset: actual ready=%0b rsp=%0b mreq=%0b expected 1 0 0", req_ready, rsp_valid, mem_req));

        // R1 R2 R7: first touch sets referenced, one write-back
        translate(mkva(0, 0, 'h1ABC), 0, {19'h00012, 13'h1ABC}, 2'd0, 2, 1, "R1 R2 R7 read first touch");
        chk(mem[1024] == leaf(19'h00012, 1, 1, 0, 1),
            $sformatf("R7 referenced set: actual %h expected %h", mem[1024], leaf(19'h00012, 1, 1, 0, 1)));
        // R7: no change, no write-back
        translate(mkva(0, 0, 'h0005), 0, {19'h00012, 13'h0005}, 2'd0, 2, 0, "R7 read no write-back");
        // R7: write sets dirty
        translate(mkva(0, 0, 'h0000), 1, {19'h00012, 13'h0000}, 2'd0, 2, 1, "R7 write sets dirty");
        chk(mem[1024] == leaf(19'h00012, 1, 1, 1, 1),
            $sformatf("R7 dirty set: actual %h expected %h", mem[1024], leaf(19'h00012, 1, 1, 1, 1)));
        // R4: invalid leaf with other bits set
        translate(mkva(0, 3, 'h0123), 0, 32'h0, 2'd1, 2, 0, "R4 invalid leaf");
        chk(mem[1027] == leaf(19'h7AAAA, 0, 1, 1, 1),
            $sformatf("R4 leaf untouched: actual %h expected %h", mem[1027], leaf(19'h7AAAA, 0, 1, 1, 1)));
        // R3: invalid top-level entry
        translate(mkva(1, 0, 'h0010), 0, 32'h0, 2'd1, 1, 0, "R3 invalid top entry");
        // R6: write to read-only page
        translate(mkva(0, 5, 'h0777), 1, 32'h0, 2'd2, 2, 0, "R6 write denied");
        chk(mem[1029] == leaf(19'h00345, 1, 0, 0, 0),
            $sformatf("R6 leaf untouched: actual %h expected %h", mem[1029], leaf(19'h00345, 1, 0, 0, 0)));
        translate(mkva(0, 5, 'h0777), 0, {19'h00345, 13'h0777}, 2'd0, 2, 1, "R6 read allowed");
        // R1: extremes of index and offset
        translate(mkva(2, 511, 'h1FFF), 1, 32'hFFFF_FFFF, 2'd0, 2, 0, "R1 extreme indexes");
        // R7: referenced already set, write adds dirty
        translate(mkva(2, 1, 'h0040), 1, {19'h00077, 13'h0040}, 2'd0, 2, 1, "R7 write on referenced page");
        chk(mem[1537] == leaf(19'h00077, 1, 1, 1, 1),
            $sformatf("R7 dirty only: actual %h expected %h", mem[1537], leaf(19'h00077, 1, 1, 1, 1)));
        // R5: limit boundary
        translate(mkva(7, 0, 'h0001), 0, 32'h0, 2'd1, 1, 0, "R5 index below length walked");
        translate(mkva(8, 0, 'h0001), 0, 32'h0, 2'd3, 0, 0, "R5 index at length");
        translate(mkva(1023, 0, 'h0001), 0, 32'h0, 2'd3, 0, 0, "R5 top index");
        tbl_len = 11'd0;
        translate(mkva(0, 0, 'h0001), 0, 32'h0, 2'd3, 0, 0, "R5 zero length");
        tbl_len = 11'd1024;
        translate(mkva(1023, 0, 'h0001), 0, 32'h0, 2'd1, 1, 0, "R5 full length");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule